// File: doc/BRIEF.md
# I2C Slave Controller with Clock Stretching

This block is a 7-bit-address I2C target for a peripheral subsystem. It oversamples SCL and SDA with the system clock, finds START, repeated START and STOP on the bus, and collects the address byte. When the byte names the programmed own address, or the all-zero broadcast address while broadcast response is enabled, it acknowledges. It also raises a "selected" event and holds SCL low. Software then writes the status register to let the bus continue.

In a write transfer each received byte is captured, acknowledged when acknowledge is enabled, and SCL is held low with a "byte done" event. In a read transfer the slave shifts bytes out of the data register MSB first. After the master's acknowledge bit it reports the acknowledge outcome and again holds SCL low. A negative acknowledge makes it fall silent until the next START or STOP. A STOP seen while addressed raises a stop event. Every change of the slave's SDA drive waits a programmable number of system clocks after the detected SCL falling edge. Both lines are driven as open drain, through low-drive enables.

Top module: `i2c_slv_top`

## Requirements
- R1: After reset both low-drive enables and `irq_o` are 0, and the status register (offset 3) reads 0.
- R2: A START (SDA falling while SCL is high) begins address reception, with bits taken MSB first on SCL rising edges. If bits 7:1 equal the own address (offset 0, bits 6:0) and acknowledge is enabled (offset 1, bit 0), the slave sets status bit 0 (selected), raises `irq_o`, holds SCL low and drives the ACK bit low.
- R3: With broadcast enabled (offset 1, bit 1), address 0x00 matches as in R2 and also sets status bit 5.
- R4: On a non-matching address the slave does not acknowledge and raises no event. It leaves SCL and SDA alone until the next START, and a later STOP sets no stop flag.
- R5: A matching address while acknowledge is disabled is handled exactly like a non-matching one.
- R6: Any write to the status register clears status bits 0 to 2, drops `irq_o` and releases SCL one clock later. SCL is never held low without a pending event.
- R7: In a write transfer, after 8 data bits the byte reads back at offset 2. The slave sets status bit 1 (byte done), holds SCL low, and drives ACK low when acknowledge is enabled.
- R8: When the R/W bit (address bit 0) is 1, status bit 3 is set. Bytes written to offset 2 are sent MSB first. After the master's acknowledge bit the slave sets status bit 1 and holds SCL low whatever the outcome. Status bit 4 is 1 when the master acknowledged and 0 when it did not.
- R9: After a negative acknowledge from the master, the slave drives SDA no more and raises no event until a START or STOP.
- R10: A repeated START in the middle of a transfer restarts address reception, and a matching address selects the slave again without setting the stop flag.
- R11: A STOP while addressed sets status bit 2 and raises `irq_o`, and the slave becomes idle.
- R12: With hold count H (offset 4), the SDA drive changes H+4 system clocks after SCL falls at the pin: two synchronizer stages, one edge register, H waiting clocks and the output register. The bench accepts H+3 to H+5.
- R13: The slave's SDA drive changes only while SCL on the bus is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL level on the bus |
| sda_i | input | 1 | SDA level on the bus |
| scl_low_o | output | 1 | Pull SCL low (stretch) |
| sda_low_o | output | 1 | Pull SDA low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register offset: 0 own address, 1 control, 2 data, 3 status, 4 hold count |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for `reg_addr_i` (combinational) |
| irq_o | output | 1 | High while the selected, byte-done or stop flag is pending |

## Verification
The hardest state to reach is a read transfer at its end, where the master's negative acknowledge has to be seen by the slave and the slave must then release SDA and stay quiet. The bench master reaches it by clocking two bytes out of the slave. It acknowledges the first and refuses the second, and only after the status-register release does it read a further byte. That byte must come back as all ones with no stretch. A repeated START issued right after a received byte, and a transfer run with a non-zero hold count while the drive delay is timed in clocks, cover the other hard-to-reach orderings.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
  localparam int REG_AW = 3;
  typedef logic [REG_AW-1:0] reg_addr_t;

  localparam reg_addr_t REG_OWN  = 3'd0;
  localparam reg_addr_t REG_CTRL = 3'd1;
  localparam reg_addr_t REG_DATA = 3'd2;
  localparam reg_addr_t REG_STAT = 3'd3;
  localparam reg_addr_t REG_HOLD = 3'd4;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_RX, ST_RX_ACK,
    ST_TX, ST_TX_ACK, ST_TX_WAIT, ST_TX_DONE
  } state_e;
endpackage

// File: rtl/i2c_slv_sync.sv
module i2c_slv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [1:0] pin, synced, prev;
  assign pin = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain <= '1;
      else         chain <= {chain[STAGES-2:0], pin[g]};
    end
    assign synced[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev <= 2'b11;
    else         prev <= synced;
  end

  assign sda_o      = synced[1];
  assign scl_rise_o = synced[0] & ~prev[0];
  assign scl_fall_o = ~synced[0] & prev[0];
  // SDA edge while SCL stays high
  assign start_o    = synced[0] & prev[0] & prev[1] & ~synced[1];
  assign stop_o     = synced[0] & prev[0] & ~prev[1] & synced[1];
endmodule

// File: rtl/i2c_slv_hold.sv
module i2c_slv_hold #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fall_i,
  input  logic             clr_i,
  input  logic             want_i,
  input  logic [CNT_W-1:0] hold_i,
  output logic             drive_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '1;
    else if (fall_i)      cnt_q <= '0;
    else if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              drive_o <= 1'b0;
    else if (clr_i)           drive_o <= 1'b0;
    else if (cnt_q >= hold_i) drive_o <= want_i;
  end
endmodule

// File: rtl/i2c_slv_top.sv
module i2c_slv_top
  import i2c_slv_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_low_o,
  output logic              sda_low_o,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic              irq_o
);
  localparam int BYTE_W = 8;
  localparam int ADR_W  = BYTE_W - 1;

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  state_e state_q;
  logic [ADR_W-1:0]  own_q;
  logic [BYTE_W-1:0] tx_q, rx_q, sh_q;
  logic [HOLD_W-1:0] hold_q;
  logic [3:0] cnt_q;
  logic ack_en_q, gc_en_q, want_q, stretch_q;
  logic sel_q, tend_q, stop_q, txm_q, mack_q, gc_hit_q;
  logic stat_wr, own_hit, gc_hit;

  i2c_slv_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  i2c_slv_hold #(.CNT_W(HOLD_W)) u_hold (
    .clk_i, .rst_ni, .fall_i(scl_fall), .clr_i(start_det | stop_det),
    .want_i(want_q), .hold_i(hold_q), .drive_o(sda_low_o)
  );

  assign stat_wr = reg_wr_i && (reg_addr_i == REG_STAT);
  assign gc_hit  = gc_en_q && (sh_q[BYTE_W-1:1] == '0);
  assign own_hit = (sh_q[BYTE_W-1:1] == own_q) || gc_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;  own_q <= '0; tx_q <= '0; rx_q <= '0; sh_q <= '0;
      hold_q <= '0; cnt_q <= '0; ack_en_q <= 1'b0; gc_en_q <= 1'b0;
      want_q <= 1'b0; stretch_q <= 1'b0; sel_q <= 1'b0; tend_q <= 1'b0;
      stop_q <= 1'b0; txm_q <= 1'b0; mack_q <= 1'b0; gc_hit_q <= 1'b0;
    end else begin
      if (reg_wr_i) begin
        case (reg_addr_i)
          REG_OWN:  own_q <= reg_wdata_i[ADR_W-1:0];
          REG_CTRL: begin ack_en_q <= reg_wdata_i[0]; gc_en_q <= reg_wdata_i[1]; end
          REG_DATA: tx_q <= reg_wdata_i;
          REG_HOLD: hold_q <= HOLD_W'(reg_wdata_i);
          default: ;
        endcase
      end
      if (stat_wr) begin
        sel_q <= 1'b0; tend_q <= 1'b0; stop_q <= 1'b0; stretch_q <= 1'b0;
        if (state_q == ST_TX_WAIT) begin
          if (mack_q) begin
            state_q <= ST_TX; sh_q <= tx_q; want_q <= ~tx_q[BYTE_W-1]; cnt_q <= '0;
          end else begin
            state_q <= ST_TX_DONE;
          end
        end
      end
      if (start_det) begin
        state_q <= ST_ADDR; cnt_q <= '0; want_q <= 1'b0; stretch_q <= 1'b0;
      end else if (stop_det) begin
        if (state_q != ST_IDLE) stop_q <= 1'b1;
        state_q <= ST_IDLE; want_q <= 1'b0; stretch_q <= 1'b0;
      end else begin
        case (state_q)
          ST_ADDR, ST_RX: begin
            if (scl_rise) begin
              sh_q  <= {sh_q[BYTE_W-2:0], sda_s};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall && cnt_q == 4'(BYTE_W)) begin
              if (state_q == ST_RX) begin
                rx_q <= sh_q; tend_q <= 1'b1; stretch_q <= 1'b1;
                want_q <= ack_en_q; state_q <= ST_RX_ACK;
              end else if (own_hit && ack_en_q) begin
                sel_q <= 1'b1; txm_q <= sh_q[0]; gc_hit_q <= gc_hit;
                stretch_q <= 1'b1; want_q <= 1'b1; state_q <= ST_ADDR_ACK;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: if (scl_fall) begin
            cnt_q <= '0;
            if (txm_q) begin
              state_q <= ST_TX; sh_q <= tx_q; want_q <= ~tx_q[BYTE_W-1];
            end else begin
              state_q <= ST_RX; want_q <= 1'b0;
            end
          end
          ST_RX_ACK: if (scl_fall) begin
            state_q <= ST_RX; want_q <= 1'b0; cnt_q <= '0;
          end
          ST_TX: if (scl_fall) begin
            if (cnt_q == 4'(BYTE_W-1)) begin
              want_q <= 1'b0; state_q <= ST_TX_ACK;
            end else begin
              sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
              want_q <= ~sh_q[BYTE_W-2];
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) mack_q <= ~sda_s;
            else if (scl_fall) begin
              tend_q <= 1'b1; stretch_q <= 1'b1; state_q <= ST_TX_WAIT;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr_i)
      REG_OWN:  reg_rdata_o = {1'b0, own_q};
      REG_CTRL: reg_rdata_o = {6'b0, gc_en_q, ack_en_q};
      REG_DATA: reg_rdata_o = rx_q;
      REG_STAT: reg_rdata_o = {2'b0, gc_hit_q, mack_q, txm_q, stop_q, tend_q, sel_q};
      REG_HOLD: reg_rdata_o = 8'(hold_q);
      default:  reg_rdata_o = '0;
    endcase
  end

  assign scl_low_o = stretch_q;
  assign irq_o     = sel_q | tend_q | stop_q;
endmodule

// File: rtl/i2c_slv_chk.sv
module i2c_slv_chk
  import i2c_slv_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_low_o,
  input logic              sda_low_o,
  input logic              irq_o,
  input logic              reg_wr_i,
  input logic [REG_AW-1:0] reg_addr_i,
  input logic              sel_flag,
  input logic              stop_flag,
  input logic              stop_det,
  input logic              scl_fall,
  input state_e            state_i
);
  logic stat_wr;
  assign stat_wr = reg_wr_i && (reg_addr_i == REG_STAT);

  // R6
  stretch_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_low_o |-> irq_o);

  // R6
  stat_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_wr && !scl_fall) |=> !scl_low_o);

  // R11
  stop_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stop_flag) |-> $past(stop_det));

  // R2
  sel_stretch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sel_flag) |-> scl_low_o);

  // R4
  addr_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_ADDR) |-> !sda_low_o);
endmodule

bind i2c_slv_top i2c_slv_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_low_o(scl_low_o), .sda_low_o(sda_low_o),
  .irq_o(irq_o), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
  .sel_flag(sel_q), .stop_flag(stop_q), .stop_det(stop_det),
  .scl_fall(scl_fall), .state_i(state_q)
);

// File: tb/i2c_slv_top_tb_top.sv
`timescale 1ns/1ps
module i2c_slv_top_tb_top;
  localparam int Q = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic scl_low, sda_low, irq;
  logic scl_bus, sda_bus;
  int n_chk = 0, n_err = 0, mon_r13 = 0, mon_r6 = 0;
  bit done = 0;

  always #4 clk = ~clk;
  assign scl_bus = scl_m & ~scl_low;
  assign sda_bus = sda_m & ~sda_low;

  i2c_slv_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_low_o(scl_low), .sda_low_o(sda_low), .reg_wr_i(reg_wr),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .irq_o(irq)
  );

  // every-clock model checks: R13 drive steady while SCL high, R6 stretch implies event
  logic prev_drv = 1'b0, prev_scl = 1'b1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (sda_low !== prev_drv && prev_scl && scl_bus) mon_r13++;
      if (scl_low && !irq) mon_r6++;
    end
    prev_drv = sda_low;
    prev_scl = scl_bus;
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_rng(string tag, int act, int lo, int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic scl_up();
    scl_m = 1'b1;
    @(negedge clk);
    while (!scl_bus) @(negedge clk);
  endtask

  task automatic wr_reg(logic [2:0] a, logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_reg(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic release_bus(string tag);
    wr_reg(3'd3, 8'h00);
    chk({tag, " stretch released"}, scl_low, 0);
    chk({tag, " irq cleared"}, irq, 0);
  endtask

  task automatic start_c();
    sda_m = 1'b1; wq(); scl_up(); wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic stop_c();
    sda_m = 1'b0; wq(); scl_up(); wq(); sda_m = 1'b1; wq();
  endtask

  task automatic wbit(logic b);
    sda_m = b; wq(); scl_up(); wq(); scl_m = 1'b0; wq();
  endtask

  task automatic rbit(output logic b);
    sda_m = 1'b1; wq(); scl_up(); wq(); b = sda_bus; scl_m = 1'b0; wq();
  endtask

  // returns clocks from final SCL fall until the slave pulls SDA, 0 if never
  task automatic wbyte(logic [7:0] v, output int dly);
    for (int i = 7; i > 0; i--) wbit(v[i]);
    sda_m = v[0]; wq(); scl_up(); wq(); scl_m = 1'b0;
    dly = 0;
    for (int i = 1; i <= Q; i++) begin
      @(negedge clk);
      if (dly == 0 && sda_low) dly = i;
    end
  endtask

  task automatic rbyte(output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      rbit(b);
      v[i] = b;
    end
  endtask

  initial begin
    logic [7:0] d;
    logic a;
    int dly;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd_reg(3'd3, d);
    chk("R1 status", d, 0);
    chk("R1 scl drive", scl_low, 0);
    chk("R1 sda drive", sda_low, 0);
    chk("R1 irq", irq, 0);

    wr_reg(3'd0, 8'h3A);
    wr_reg(3'd1, 8'h01);
    wr_reg(3'd4, 8'h00);

    // write transfer
    start_c();
    wbyte(8'h74, dly);
    rd_reg(3'd3, d);
    chk("R2 selected", d & 8'h07, 8'h01);
    chk("R2 irq", irq, 1);
    chk("R2 stretch", scl_low, 1);
    chk_rng("R12 hold 0 delay", dly, 3, 5);
    release_bus("R6");
    rbit(a);
    chk("R2 addr ack", a, 0);
    wbyte(8'hA5, dly);
    rd_reg(3'd2, d);
    chk("R7 rx data", d, 8'hA5);
    rd_reg(3'd3, d);
    chk("R7 byte done", d & 8'h07, 8'h02);
    chk("R7 stretch", scl_low, 1);
    release_bus("R6");
    rbit(a);
    chk("R7 data ack", a, 0);
    stop_c();
    rd_reg(3'd3, d);
    chk("R11 stop flag", d & 8'h07, 8'h04);
    chk("R11 irq", irq, 1);
    release_bus("R11");

    // mismatch
    start_c();
    wbyte(8'h22, dly);
    chk("R4 no drive", dly, 0);
    chk("R4 no irq", irq, 0);
    chk("R4 no stretch", scl_low, 0);
    rbit(a);
    chk("R4 nack", a, 1);
    wbyte(8'h00, dly);
    chk("R4 data ignored", irq, 0);
    rbit(a);
    chk("R4 data nack", a, 1);
    stop_c();
    rd_reg(3'd3, d);
    chk("R4 no stop flag", d & 8'h07, 0);

    // acknowledge disabled
    wr_reg(3'd1, 8'h00);
    start_c();
    wbyte(8'h74, dly);
    chk("R5 no irq", irq, 0);
    chk("R5 no stretch", scl_low, 0);
    rbit(a);
    chk("R5 nack", a, 1);
    stop_c();
    chk("R5 no stop", irq, 0);

    // broadcast address
    wr_reg(3'd1, 8'h03);
    start_c();
    wbyte(8'h00, dly);
    rd_reg(3'd3, d);
    chk("R3 broadcast match", d & 8'h27, 8'h21);
    release_bus("R3");
    rbit(a);
    chk("R3 ack", a, 0);
    stop_c();
    release_bus("R11");
    wr_reg(3'd1, 8'h01);
    start_c();
    wbyte(8'h00, dly);
    chk("R3 broadcast off", irq, 0);
    rbit(a);
    chk("R3 broadcast off nack", a, 1);
    stop_c();

    // read transfer
    start_c();
    wbyte(8'h75, dly);
    rd_reg(3'd3, d);
    chk("R8 selected read", d & 8'h0F, 8'h09);
    wr_reg(3'd2, 8'hC3);
    release_bus("R8");
    rbit(a);
    chk("R8 addr ack", a, 0);
    rbyte(d);
    chk("R8 byte 1", d, 8'hC3);
    wbit(1'b0);
    rd_reg(3'd3, d);
    chk("R8 master ack", d & 8'h1F, 8'h1A);
    chk("R8 stretch after ack", scl_low, 1);
    wr_reg(3'd2, 8'h5E);
    release_bus("R8");
    rbyte(d);
    chk("R8 byte 2", d, 8'h5E);
    wbit(1'b1);
    rd_reg(3'd3, d);
    chk("R8 master nack", d & 8'h1F, 8'h0A);
    chk("R8 stretch after nack", scl_low, 1);
    release_bus("R9");
    rbyte(d);
    chk("R9 silent after nack", d, 8'hFF);
    chk("R9 no event", irq, 0);
    stop_c();
    rd_reg(3'd3, d);
    chk("R11 stop after read", d & 8'h07, 8'h04);
    release_bus("R11");

    // repeated start
    start_c();
    wbyte(8'h74, dly);
    release_bus("R10");
    rbit(a);
    wbyte(8'h3C, dly);
    rd_reg(3'd2, d);
    chk("R7 rx second", d, 8'h3C);
    release_bus("R10");
    rbit(a);
    start_c();
    wbyte(8'h75, dly);
    rd_reg(3'd3, d);
    chk("R10 reselected", d & 8'h0F, 8'h09);
    wr_reg(3'd2, 8'h81);
    release_bus("R10");
    rbit(a);
    chk("R10 ack", a, 0);
    rbyte(d);
    chk("R10 byte", d, 8'h81);
    wbit(1'b1);
    release_bus("R10");
    stop_c();
    release_bus("R11");

    // hold count
    wr_reg(3'd4, 8'd25);
    start_c();
    wbyte(8'h74, dly);
    chk_rng("R12 hold 25 addr ack", dly, 28, 30);
    release_bus("R12");
    rbit(a);
    wbyte(8'h96, dly);
    chk_rng("R12 hold 25 data ack", dly, 28, 30);
    rd_reg(3'd2, d);
    chk("R12 rx data", d, 8'h96);
    release_bus("R12");
    rbit(a);
    chk("R12 ack", a, 0);
    stop_c();
    release_bus("R11");

    chk("R13 drive steady while SCL high", mon_r13, 0);
    chk("R6 stretch without event", mon_r6, 0);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule